// File: doc/BRIEF.md
# Bouncing One-Hot Channel Sequencer with Adjustable Overlap

This block steps through eight channels one at a time. It moves up from the first channel to the last, then back down, and the two end channels are not repeated at the turnaround. Three digital settings control it: the step length in clock cycles, the fraction of each step during which the channel is driven, and an overlap fraction. The overlap keeps the previous channel on for the opening part of the next step, so that two neighbouring channels are on together for a short time (make before break).

Two 8-bit buses, one for the high-side switches and one for the low-side switches, carry the same pattern on the same cycle. An indicator output is pulse-width modulated so that its brightness follows the overlap setting. The number of steps per second is the clock rate divided by the step length. A step length of zero stops the scan. With a suitable clock, the rate can therefore be set anywhere from a standstill up to about 100 steps per second. All three settings are sampled only when one step ends and the next begins. They are also sampled on every cycle while the scan is stopped.

Top module: `bounce_scan_seq`

## Requirements
- R1: Bit i of each bus stands for channel i+1. The driven channel follows the order 1,2,3,4,5,6,7,8,7,6,5,4,3,2 and then starts again at 1. Each step lasts exactly P clock cycles, where P is the latched step length.
- R2: With duty 255 and overlap 0, exactly one bus bit is set on every cycle. The next channel turns on in the same cycle that the previous one turns off.
- R3: With duty D below 255, the current channel is on for the first floor(P*D/256) cycles of its step. For the rest of the step the bus is all zero.
- R4: With duty 255 and overlap V, the previous channel stays on for the first floor(P*min(V,64)/256) cycles of each step, together with the current channel. Values of V above 64 act as 64, which is 25% of the step.
- R5: When duty is below 255, the overlap setting has no effect, and at most one bus bit is ever set.
- R6: The high-side bus and the low-side bus are equal on every cycle.
- R7: The indicator runs on a 256-cycle frame and is high for min(V,64)*4 cycles of every 256 consecutive cycles, where V is the latched overlap. It is never high when V is 0 and always high when V is 64 or more.
- R8: A latched step length of 0 freezes the scan. The current channel stays on by itself and the step counter stays at zero. The first step after the scan restarts shows no overlap.
- R9: A change to the settings while a step is running has no effect until that step ends. The running step keeps its length, duty and overlap.
- R10: After synchronous reset, channel 1 is on, the direction is upward, every counter is zero, the settings read as zero, and the indicator is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| step_period | input | 16 | Step length in clock cycles; 0 stops the scan |
| duty_frac | input | 8 | On-time fraction of the step in 1/256 units; 255 means full duty |
| ovl_frac | input | 8 | Overlap fraction of the step in 1/256 units, limited to 64 |
| hi_bus | output | 8 | High-side channel pattern |
| lo_bus | output | 8 | Low-side channel pattern, always equal to hi_bus |
| ovl_led | output | 1 | PWM indicator whose duty follows the overlap setting |

## Verification
The case that most needs attention is the first cycle of a step. In that cycle the new channel switches on, the overlap window holds the previous channel on, and the settings are latched, all at once. The bench provokes this in three ways. It changes the settings in the middle of a step. It sets an overlap above the 25% limit. It stops the scan and restarts it. A behavioural model, built on a phase number that counts 0 to 13, predicts the bus and the indicator for every cycle. It is checked against the outputs on every cycle. Directed checks then look at the number of set bits at each step offset, at the exact cycle on which the channel changes, and at the number of high indicator cycles in a 256-cycle frame.

// File: rtl/bss_pkg.sv
package bss_pkg;
    localparam int PER_W  = 16;
    localparam int FRAC_W = 8;
    localparam logic [FRAC_W-1:0] DUTY_FULL = '1;
    localparam logic [FRAC_W-1:0] OVL_CAP   = FRAC_W'(1 << (FRAC_W - 2));

    typedef struct packed {
        logic [PER_W-1:0]  per;
        logic [FRAC_W-1:0] duty;
        logic [FRAC_W-1:0] ovl;
    } step_cfg_t;

    typedef enum logic {DIR_UP = 1'b0, DIR_DN = 1'b1} scan_dir_t;

    function automatic logic [FRAC_W-1:0] ovl_clip(input logic [FRAC_W-1:0] v);
        return (v > OVL_CAP) ? OVL_CAP : v;
    endfunction

    function automatic logic [PER_W-1:0] frac_of(input logic [PER_W-1:0] p,
                                                  input logic [FRAC_W-1:0] f);
        logic [PER_W+FRAC_W-1:0] prod;
        prod = {{FRAC_W{1'b0}}, p} * {{PER_W{1'b0}}, f};
        return prod[PER_W+FRAC_W-1:FRAC_W];
    endfunction
endpackage

// File: rtl/bss_step_timer.sv
module bss_step_timer
    import bss_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  step_cfg_t        cfg_in,
    output step_cfg_t        cfg_q,
    output logic [PER_W-1:0] cnt,
    output logic             step_adv,
    output logic             frozen
);
    assign frozen   = (cfg_q.per == '0);
    assign step_adv = !frozen && (cnt == cfg_q.per - PER_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
            cnt   <= '0;
        end else if (frozen || step_adv) begin
            cfg_q <= cfg_in;
            cnt   <= '0;
        end else begin
            cnt   <= cnt + PER_W'(1);
        end
    end

    // R9
    cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!frozen && !step_adv) |=> $stable(cfg_q));
    // R8
    freeze_cnt_chk: assert property (@(posedge clk) disable iff (rst)
        frozen |=> (cnt == '0));
    // R1
    cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        !frozen |-> (cnt < cfg_q.per));
endmodule

// File: rtl/bss_bounce_pos.sv
module bss_bounce_pos
    import bss_pkg::*;
#(
    parameter int NCH = 8,
    localparam int IDX_W = $clog2(NCH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step_adv,
    input  logic             frozen,
    output logic [IDX_W-1:0] cur_idx,
    output logic [IDX_W-1:0] prev_idx,
    output logic             prev_vld
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(NCH - 1);

    scan_dir_t dir;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_idx  <= '0;
            prev_idx <= '0;
            prev_vld <= 1'b0;
            dir      <= DIR_UP;
        end else if (frozen) begin
            prev_vld <= 1'b0;
        end else if (step_adv) begin
            prev_idx <= cur_idx;
            prev_vld <= 1'b1;
            case (dir)
                DIR_UP: begin
                    if (cur_idx == LAST) begin
                        cur_idx <= LAST - IDX_W'(1);
                        dir     <= DIR_DN;
                    end else begin
                        cur_idx <= cur_idx + IDX_W'(1);
                    end
                end
                default: begin
                    if (cur_idx == '0) begin
                        cur_idx <= IDX_W'(1);
                        dir     <= DIR_UP;
                    end else begin
                        cur_idx <= cur_idx - IDX_W'(1);
                    end
                end
            endcase
        end
    end

    // R1
    neighbour_step_chk: assert property (@(posedge clk) disable iff (rst)
        step_adv |=> ((cur_idx == $past(cur_idx) + IDX_W'(1)) ||
                      (cur_idx == $past(cur_idx) - IDX_W'(1))));
    // R1
    no_repeat_chk: assert property (@(posedge clk) disable iff (rst)
        step_adv |=> (prev_vld && (cur_idx != prev_idx)));
endmodule

// File: rtl/bss_ovl_led.sv
module bss_ovl_led
    import bss_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [FRAC_W-1:0] ovl_q,
    output logic              led
);
    logic [FRAC_W-1:0] pwm;
    logic [FRAC_W:0]   thr;

    assign thr = (FRAC_W+1)'(ovl_clip(ovl_q)) << 2;
    assign led = ({1'b0, pwm} < thr);

    always_ff @(posedge clk) begin
        if (rst) pwm <= '0;
        else     pwm <= pwm + FRAC_W'(1);
    end

    // R7
    led_dark_chk: assert property (@(posedge clk) disable iff (rst)
        (ovl_q == '0) |-> !led);
    // R7
    led_full_chk: assert property (@(posedge clk) disable iff (rst)
        (ovl_q >= OVL_CAP) |-> led);
endmodule

// File: rtl/bounce_scan_seq.sv
module bounce_scan_seq
    import bss_pkg::*;
#(
    parameter int NCH = 8,
    localparam int IDX_W = $clog2(NCH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [PER_W-1:0]  step_period,
    input  logic [FRAC_W-1:0] duty_frac,
    input  logic [FRAC_W-1:0] ovl_frac,
    output logic [NCH-1:0]    hi_bus,
    output logic [NCH-1:0]    lo_bus,
    output logic              ovl_led
);
    step_cfg_t        cfg_in, cfg_q;
    logic [PER_W-1:0] cnt, on_len, ovl_len;
    logic             step_adv, frozen, full, in_on, ovl_on, prev_vld;
    logic [IDX_W-1:0] cur_idx, prev_idx;
    logic [NCH-1:0]   ch_out;

    assign cfg_in = '{per: step_period, duty: duty_frac, ovl: ovl_frac};

    bss_step_timer u_timer (
        .clk(clk), .rst(rst), .cfg_in(cfg_in), .cfg_q(cfg_q),
        .cnt(cnt), .step_adv(step_adv), .frozen(frozen)
    );

    bss_bounce_pos #(.NCH(NCH)) u_pos (
        .clk(clk), .rst(rst), .step_adv(step_adv), .frozen(frozen),
        .cur_idx(cur_idx), .prev_idx(prev_idx), .prev_vld(prev_vld)
    );

    bss_ovl_led u_led (
        .clk(clk), .rst(rst), .ovl_q(cfg_q.ovl), .led(ovl_led)
    );

    assign full    = (cfg_q.duty == DUTY_FULL);
    assign on_len  = full ? cfg_q.per : frac_of(cfg_q.per, cfg_q.duty);
    assign ovl_len = frac_of(cfg_q.per, ovl_clip(cfg_q.ovl));
    assign in_on   = (cnt < on_len);
    assign ovl_on  = full && prev_vld && (cnt < ovl_len);

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        logic is_cur, is_prev;
        assign is_cur    = (cur_idx == IDX_W'(g));
        assign is_prev   = (prev_idx == IDX_W'(g));
        assign ch_out[g] = frozen ? is_cur : ((is_cur && in_on) || (is_prev && ovl_on));
    end

    assign hi_bus = ch_out;
    assign lo_bus = ch_out;

    // R2
    single_on_chk: assert property (@(posedge clk) disable iff (rst)
        (!frozen && full && cfg_q.ovl == '0) |-> ($countones(hi_bus) == 1));
    // R4
    max_two_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(hi_bus) <= 2);
    // R5
    duty_no_ovl_chk: assert property (@(posedge clk) disable iff (rst)
        (!frozen && !full) |-> ($countones(hi_bus) <= 1));
    // R8
    freeze_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (frozen && $past(frozen)) |-> $stable(hi_bus));
endmodule

// File: tb/bounce_scan_seq_test.sv
module bounce_scan_seq_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] per_in  = '0;
    logic [7:0]  duty_in = '0;
    logic [7:0]  ovl_in  = '0;
    logic [7:0]  hi, lo;
    logic        led;

    int checks = 0;
    int fails  = 0;
    bit cmp_en = 1'b0;

    // behavioural model state
    int m_per = 0, m_duty = 0, m_ov = 0, m_cnt = 0;
    int m_phase = 0, m_prev = 0, m_pv = 0, m_pwm = 0;

    bounce_scan_seq uut (
        .clk(clk), .rst(rst), .step_period(per_in), .duty_frac(duty_in),
        .ovl_frac(ovl_in), .hi_bus(hi), .lo_bus(lo), .ovl_led(led)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int chan_of(input int ph);
        return (ph < 8) ? ph : 14 - ph;
    endfunction

    function automatic int capv(input int v);
        return (v > 64) ? 64 : v;
    endfunction

    function automatic logic [7:0] exp_bus();
        int on_c, ov_c;
        logic [7:0] v;
        if (m_per == 0) return 8'(1 << chan_of(m_phase));
        on_c = (m_duty == 255) ? m_per : (m_per * m_duty) / 256;
        ov_c = (m_per * capv(m_ov)) / 256;
        v = (m_cnt < on_c) ? 8'(1 << chan_of(m_phase)) : 8'h00;
        if (m_duty == 255 && m_pv != 0 && m_cnt < ov_c) v = v | 8'(1 << m_prev);
        return v;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    always @(posedge clk) begin
        if (rst) begin
            m_per = 0; m_duty = 0; m_ov = 0; m_cnt = 0;
            m_phase = 0; m_prev = 0; m_pv = 0; m_pwm = 0;
        end else begin
            if (m_per == 0) begin
                m_per = per_in; m_duty = duty_in; m_ov = ovl_in;
                m_cnt = 0; m_pv = 0;
            end else if (m_cnt == m_per - 1) begin
                m_prev  = chan_of(m_phase);
                m_pv    = 1;
                m_phase = (m_phase + 1) % 14;
                m_cnt   = 0;
                m_per = per_in; m_duty = duty_in; m_ov = ovl_in;
            end else begin
                m_cnt = m_cnt + 1;
            end
            m_pwm = (m_pwm + 1) % 256;
        end
    end

    always @(negedge clk) begin
        if (cmp_en) begin
            string tag;
            logic [7:0] e;
            bit e_led;
            e = exp_bus();
            e_led = (m_pwm < capv(m_ov) * 4);
            if (m_per == 0)        tag = "R8";
            else if (m_duty != 255) tag = "R3";
            else if (m_ov > 0)     tag = "R4";
            else                   tag = "R1";
            chk(hi == e, tag, hi, e);
            chk(lo == hi, "R6", lo, hi);
            chk(led == e_led, "R7", led, e_led);
        end
    end

    // stop, show the held pattern, then start with new settings at step offset 0
    task automatic load(input int p, input int d, input int o);
        logic [7:0] held;
        per_in = 16'd0;
        while (m_per != 0) cyc(1);
        cyc(1);
        held = hi;
        cyc(10);
        chk(hi == held, "R8", hi, held);
        per_in = 16'(p); duty_in = 8'(d); ovl_in = 8'(o);
        cyc(1);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] v, w;
        int n;
        cyc(3);
        chk(hi == 8'h01, "R10", hi, 8'h01);
        chk(led == 1'b0, "R10", led, 0);
        cmp_en = 1'b1;
        per_in = 16'd4; duty_in = 8'd255; ovl_in = 8'd0;
        rst = 1'b0;
        cyc(1);
        // R1 order and step length; R2 single channel
        for (int k = 0; k < 16; k++) begin
            chk(hi == 8'(1 << chan_of(k % 14)), "R1", hi, 1 << chan_of(k % 14));
            for (int j = 0; j < 4; j++) begin
                chk($countones(hi) == 1, "R2", $countones(hi), 1);
                cyc(1);
            end
        end
        // R3 partial duty
        load(8, 128, 0);
        for (int k = 0; k < 3; k++)
            for (int j = 0; j < 8; j++) begin
                chk((hi != 0) == (j < 4), "R3", hi, j < 4);
                cyc(1);
            end
        // R5 overlap ignored below full duty
        load(8, 128, 64);
        for (int j = 0; j < 32; j++) begin
            chk($countones(hi) <= 1, "R5", $countones(hi), 1);
            cyc(1);
        end
        // R4 overlap clipped to 25%; R8 no overlap in first step after restart
        load(8, 255, 200);
        chk($countones(hi) == 1, "R8", $countones(hi), 1);
        cyc(8);
        for (int k = 0; k < 3; k++)
            for (int j = 0; j < 8; j++) begin
                chk($countones(hi) == ((j < 2) ? 2 : 1), "R4", $countones(hi), (j < 2) ? 2 : 1);
                cyc(1);
            end
        // R9 mid-step change waits for the boundary
        load(8, 255, 0);
        cyc(3);
        per_in = 16'd3;
        v = hi;
        cyc(4);
        chk(hi == v, "R9", hi, v);
        cyc(1);
        chk(hi != v, "R9", hi, v);
        w = hi;
        cyc(2);
        chk(hi == w, "R9", hi, w);
        cyc(1);
        chk(hi != w, "R9", hi, w);
        // R7 indicator brightness
        load(8, 255, 0);
        n = 0;
        for (int j = 0; j < 256; j++) begin n += led; cyc(1); end
        chk(n == 0, "R7", n, 0);
        load(8, 255, 32);
        n = 0;
        for (int j = 0; j < 256; j++) begin n += led; cyc(1); end
        chk(n == 128, "R7", n, 128);
        load(8, 255, 250);
        n = 0;
        for (int j = 0; j < 256; j++) begin n += led; cyc(1); end
        chk(n == 256, "R7", n, 256);
        // R10 reset while running
        rst = 1'b1;
        cyc(2);
        chk(hi == 8'h01, "R10", hi, 8'h01);
        chk(led == 1'b0, "R10", led, 0);
        per_in = 16'd5; duty_in = 8'd255; ovl_in = 8'd0;
        rst = 1'b0;
        cyc(20);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule